// File: doc/BRIEF.md
# Registered-Output Synchronous FIFO

This block is a single-clock first-in first-out queue. Its storage array is only ever read through a clocked read port, so the array can sit in an FPGA block RAM. The register that captures each read word is also the queue's output stage, and it counts as one more slot. A queue configured for `DEPTH` entries therefore holds `DEPTH-1` words in the array and one word in the output register.

A producer offers a word on `wr_data` and asserts `wr_en` while `wr_ready` is high. A consumer takes the word on `rd_data` while `rd_ready` is high by asserting `rd_en`. One occupancy count, `level`, serves both sides. Because the array read is registered, a word written into an empty queue needs one more cycle to reach the output than it would in a design with a combinational read path.

The parameters are `DATA_W` (word width) and `DEPTH` (total entries, at least 2).

Top module: `rof_fifo`

## Requirements
- R1: `wr_ready` is high exactly when `level` is below `DEPTH`. A `wr_en` pulse while `wr_ready` is low changes neither the stored words nor `level`.
- R2: `rd_ready` is high only when the oldest unread word is held in the output register. A `rd_en` pulse while `rd_ready` is low changes neither `level` nor `rd_data`.
- R3: Words leave in the order they were accepted, and `rd_data` carries the oldest unread word whenever `rd_ready` is high.
- R4: A read accepted at a clock edge shows the next word, if one is stored, on `rd_data` right after that edge, so reads can be back to back on every cycle.
- R5: `level` counts every unread word, including the one in the output register. It stays within 0 to `DEPTH`, and a full queue holds exactly `DEPTH` words.
- R6: A word written into an empty queue at edge N raises `level` to 1 after edge N, but `rd_ready` rises only after edge N+1.
- R7: A write and a read accepted at the same edge, while the queue is neither empty nor full, leave `level` unchanged and lose no word.
- R8: A synchronous active-high `rst` empties the queue and leaves `level` at 0, `wr_ready` high and `rd_ready` low after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | DATA_W | Word to enqueue |
| wr_en | input | 1 | Write request |
| wr_ready | output | 1 | At least one free slot |
| rd_data | output | DATA_W | Oldest unread word, valid while rd_ready is high |
| rd_en | input | 1 | Read request |
| rd_ready | output | 1 | A word is presented on rd_data |
| level | output | $clog2(DEPTH+1) | Number of unread words |

## Verification
The bench first checks the extra cycle after a write into an empty queue. A design that forwarded the word combinationally would raise `rd_ready` one cycle early, and one that never refilled the output register would hang with `level` at 1. It then fills the queue to exactly `DEPTH` words and pushes once more. A count that ignored the output register would accept a sixth word, and a missing gate on the write would overwrite the oldest entry. The bench also drains at full rate, reads during the one transient cycle when a word is stored but not yet presented, and runs simultaneous reads and writes. A refill path that lost a cycle would show up as a repeated or skipped word, and a wrong level update as a drifting count.

// File: rtl/rof_fifo_pkg.sv
package rof_fifo_pkg;

    // One cycle of queue activity as decided by the control unit.
    typedef struct packed {
        logic push;   // word accepted into the array
        logic pop;    // output word consumed
        logic load;   // array word moved into the output register
    } rof_op_t;

    // Address width for an array of n words (at least one bit).
    function automatic int unsigned addr_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Width needed to count 0..n inclusive.
    function automatic int unsigned count_bits(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rof_fifo_ptr.sv
module rof_fifo_ptr #(
    parameter int unsigned WORDS = 4,
    parameter int unsigned AW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + AW'(1);
        end
    end

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        ptr <= LAST); // R5
endmodule

// File: rtl/rof_fifo_ram.sv
module rof_fifo_ram #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned WORDS  = 4,
    parameter int unsigned AW     = 2
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    // Clocked write port.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Clocked read port with enable; read-first when addresses collide.
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/rof_fifo_ctrl.sv
module rof_fifo_ctrl
    import rof_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 5,
    parameter int unsigned LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic             wr_ready,
    output logic             rd_ready,
    output logic [LVL_W-1:0] level,
    output rof_op_t          op
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [LVL_W-1:0] level_q;
    logic             out_valid;
    logic             array_busy;

    // Words still waiting in the array (total minus the presented one).
    assign array_busy = (level_q - LVL_W'(out_valid)) != '0;

    always_comb begin
        op.push = wr_en && (level_q != FULL_LVL);
        op.pop  = rd_en && out_valid;
        op.load = array_busy && (!out_valid || op.pop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q   <= '0;
            out_valid <= 1'b0;
        end else begin
            level_q <= level_q + LVL_W'(op.push) - LVL_W'(op.pop);
            if (op.load) begin
                out_valid <= 1'b1;
            end else if (op.pop) begin
                out_valid <= 1'b0;
            end
        end
    end

    assign wr_ready = (level_q != FULL_LVL);
    assign rd_ready = out_valid;
    assign level    = level_q;

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
        level_q <= FULL_LVL); // R5
    AST_PRESENT_HAS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> level_q != '0); // R2
    AST_EMPTY_WRITE_LAG: assert property (@(posedge clk) disable iff (rst)
        (level_q == '0 && wr_en) |=> (!out_valid && level_q == LVL_W'(1))); // R6
    AST_STALLED_READ: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && rd_en && !wr_en) |=> $stable(level_q)); // R2
    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (level_q == FULL_LVL && wr_en && !rd_en) |=> level_q == FULL_LVL); // R1
endmodule

// File: rtl/rof_fifo.sv
module rof_fifo
    import rof_fifo_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 5,
    localparam int unsigned LVL_W = count_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    output logic              wr_ready,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rd_en,
    output logic              rd_ready,
    output logic [LVL_W-1:0]  level
);
    // The output register is one slot; the array holds the rest.
    localparam int unsigned ARR_WORDS = DEPTH - 1;
    localparam int unsigned AW        = addr_bits(ARR_WORDS);

    rof_op_t         op;
    logic [AW-1:0]   wptr;
    logic [AW-1:0]   rptr;

    rof_fifo_ctrl #(
        .DEPTH (DEPTH),
        .LVL_W (LVL_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wr_ready (wr_ready),
        .rd_ready (rd_ready),
        .level    (level),
        .op       (op)
    );

    rof_fifo_ptr #(
        .WORDS (ARR_WORDS),
        .AW    (AW)
    ) u_wptr (
        .clk (clk),
        .rst (rst),
        .adv (op.push),
        .ptr (wptr)
    );

    rof_fifo_ptr #(
        .WORDS (ARR_WORDS),
        .AW    (AW)
    ) u_rptr (
        .clk (clk),
        .rst (rst),
        .adv (op.load),
        .ptr (rptr)
    );

    rof_fifo_ram #(
        .DATA_W (DATA_W),
        .WORDS  (ARR_WORDS),
        .AW     (AW)
    ) u_ram (
        .clk   (clk),
        .we    (op.push),
        .waddr (wptr),
        .wdata (wr_data),
        .re    (op.load),
        .raddr (rptr),
        .rdata (rd_data)
    );

    AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ready && rd_en && rd_ready) |=> $stable(level)); // R7
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (wr_ready && !rd_ready && level == '0)); // R8
    AST_HELD_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        (rd_ready && !rd_en) |=> (rd_ready && $stable(rd_data))); // R3
endmodule

// File: tb/rof_fifo_tb.sv
module rof_fifo_tb;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 5;
    localparam int LVL_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_en = 1'b0;
    logic              wr_ready;
    logic [DATA_W-1:0] rd_data;
    logic              rd_en = 1'b0;
    logic              rd_ready;
    logic [LVL_W-1:0]  level;

    int vectors = 0;
    int errors  = 0;
    int exp_q[$];
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    rof_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
        .clk, .rst, .wr_data, .wr_en, .wr_ready,
        .rd_data, .rd_en, .rd_ready, .level
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, settle past the rising edge.
    task automatic step(input bit we, input int wd, input bit re, input string req);
        bit pre_w, pre_r;
        wr_en   = we;
        wr_data = DATA_W'(wd);
        rd_en   = re;
        pre_w   = wr_ready;
        pre_r   = rd_ready;
        if (re && pre_r) begin
            check({req, " read data"}, int'(rd_data), exp_q[0]);
            void'(exp_q.pop_front());
        end
        if (we && pre_w) exp_q.push_back(wd);
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        check({req, " level"}, int'(level), exp_q.size());
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_q.delete();
        check("R8 wr_ready", int'(wr_ready), 1);
        check("R8 rd_ready", int'(rd_ready), 0);
        check("R8 level", int'(level), 0);
    endtask

    task automatic t_latency();
        step(1, 'hA5, 0, "R6");
        check("R6 rd_ready after first edge", int'(rd_ready), 0);
        step(0, 0, 0, "R6");
        check("R6 rd_ready after second edge", int'(rd_ready), 1);
        check("R3 presented word", int'(rd_data), 'hA5);
        step(0, 0, 1, "R3");
        check("R2 rd_ready drained", int'(rd_ready), 0);
    endtask

    task automatic t_fill_drain();
        for (int i = 0; i < DEPTH; i++) begin
            step(1, 'h10 + i, 0, "R5");
            check("R1 wr_ready while filling", int'(wr_ready), (i + 1 < DEPTH) ? 1 : 0);
        end
        step(1, 'hEE, 0, "R1");       // refused write: level must stay DEPTH
        check("R5 full level", int'(level), DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            step(0, 0, 1, "R4");
            check("R4 back-to-back ready", int'(rd_ready), (i + 1 < DEPTH) ? 1 : 0);
        end
        check("R1 wr_ready empty", int'(wr_ready), 1);
    endtask

    task automatic t_stalled_read();
        logic [DATA_W-1:0] held;
        held = rd_data;
        step(0, 0, 1, "R2");
        check("R2 rd_data unchanged", int'(rd_data), int'(held));
        check("R2 rd_ready empty", int'(rd_ready), 0);
        step(1, 'h3C, 0, "R6");
        step(0, 0, 1, "R2");           // word stored but not yet presented
        check("R2 ready after transient", int'(rd_ready), 1);
        check("R3 data after transient", int'(rd_data), 'h3C);
        step(0, 0, 1, "R3");
    endtask

    task automatic t_simultaneous();
        step(1, 'h40, 0, "R7");
        step(1, 'h41, 0, "R7");
        for (int k = 0; k < 6; k++) begin
            step(1, 'h42 + k, 1, "R7");
            check("R7 level steady", int'(level), 2);
        end
        step(0, 0, 1, "R7");
        step(0, 0, 1, "R7");
        check("R7 drained", int'(level), 0);
    endtask

    task automatic t_reset_midway();
        step(1, 'h77, 0, "R8");
        step(1, 'h78, 0, "R8");
        step(0, 0, 0, "R8");
        t_reset();
        step(0, 0, 1, "R8");           // nothing may survive the reset
        check("R8 no stale word", int'(rd_ready), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_latency();
        t_fill_drain();
        t_stalled_read();
        t_simultaneous();
        t_reset_midway();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule